// File: doc/BRIEF.md
# Iterative Index-by-Accumulator Multiplier

This unit carries out the multiply instruction of a small 8-bit processor core. When the instruction decoder sees the one-byte multiply opcode (0x42, no operand bytes), it pulses `start`. The unit then multiplies the index register by the accumulator, both taken as unsigned. It hands the 16-bit product back to the register file in a single write cycle. The high byte goes to the index register and the low byte to the accumulator. In that same cycle it clears the half-carry and carry flags and returns the mask, negative and zero flags unchanged.

The sequence has a fixed length. The cycle in which `start` is seen is cycle 1. The control machine then spends a padding stage (state SETUP) and one shift-and-add step per multiplier bit (state STEP, eight cycles). It writes back in cycle 11 (state FINISH) and then returns to IDLE. The named transitions are:
- IDLE→SETUP on an accepted start.
- SETUP→STEP when the padding count runs out.
- STEP→FINISH after the last partial product.
- FINISH→IDLE unconditionally.

Operands are latched in the cycle the start is accepted. A start that arrives while the unit is busy is dropped.

Top module: `xmul_unit`

## Requirements
- R1: In the write-back cycle, `idx_out` equals bits 15:8 and `acc_out` equals bits 7:0 of the unsigned product of the `idx_in` and `acc_in` values sampled with the accepted start. This includes the corners 0×n = 0 and 0xFF×0xFF = 0xFE01.
- R2: `done` is high for exactly one cycle per accepted start. That cycle is the 11th when the start cycle counts as the 1st, so it comes 10 rising edges after the start cycle.
- R3: `acc_we` and `idx_we` are high only in the `done` cycle, and both are high in it. Outside that cycle, `acc_out` and `idx_out` are 0.
- R4: `busy` rises on the edge that accepts a start, stays high through the `done` cycle, and is low in IDLE.
- R5: In the `done` cycle, `cc_we` is 1 and both `cc_half_out` and `cc_carry_out` are 0. `cc_we` is 0 in every other cycle.
- R6: In the `done` cycle, `cc_mask_out`, `cc_neg_out` and `cc_zero_out` equal `cc_mask_in`, `cc_neg_in` and `cc_zero_in`.
- R7: A `start` pulse while `busy` is high is ignored. It adds no `done` pulse and does not alter the result or timing of the running operation.
- R8: While `rst_n` is low, `busy`, `done`, all write enables and `acc_out`/`idx_out` are 0.
- R9: Changes on `acc_in`/`idx_in` after the start cycle have no effect on the product written back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request decoded from opcode 0x42 |
| acc_in | input | 8 | Current accumulator value |
| idx_in | input | 8 | Current index register value |
| cc_half_in | input | 1 | Current half-carry flag |
| cc_mask_in | input | 1 | Current interrupt mask flag |
| cc_neg_in | input | 1 | Current negative flag |
| cc_zero_in | input | 1 | Current zero flag |
| cc_carry_in | input | 1 | Current carry flag |
| acc_out | output | 8 | Low product byte for the accumulator |
| idx_out | output | 8 | High product byte for the index register |
| acc_we | output | 1 | Accumulator write enable |
| idx_we | output | 1 | Index register write enable |
| cc_half_out | output | 1 | Half-carry flag to write |
| cc_mask_out | output | 1 | Interrupt mask flag to write |
| cc_neg_out | output | 1 | Negative flag to write |
| cc_zero_out | output | 1 | Zero flag to write |
| cc_carry_out | output | 1 | Carry flag to write |
| cc_we | output | 1 | Flag write enable |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Write-back cycle marker |

## Verification
A stuck or miscounted step counter moves the `done` cycle away from the 11th cycle, or suppresses it. The scoreboard sees this as a latency mismatch or as an entry left in its queue. A corrupted partial-product register or a lost carry only appears at write-back, so it shows as a wrong `idx_out`/`acc_out` pair in that same cycle. The all-ones and zero operands expose carry and add-enable faults. A FSM that accepts a start while busy yields either an extra unexpected `done` or an early write-back, both within about ten cycles of the stray pulse.

// File: rtl/xmul_pkg.sv
package xmul_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STEP   = 2'd2,
        ST_FINISH = 2'd3
    } xmul_state_e;
endpackage

// File: rtl/xmul_ctrl.sv
module xmul_ctrl
    import xmul_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int TOTAL_CYCLES = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic capture,
    output logic step_en,
    output logic finish,
    output logic busy
);
    localparam int PAD_CYCLES = TOTAL_CYCLES - DATA_W - 2;
    localparam int CNT_MAX    = (DATA_W > PAD_CYCLES) ? DATA_W : PAD_CYCLES;
    localparam int CNT_W      = $clog2(CNT_MAX + 1);

    xmul_state_e state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_IDLE: begin
                cnt_nx = '0;
                if (start) state_nx = ST_SETUP;
            end
            ST_SETUP: begin
                if (cnt == CNT_W'(PAD_CYCLES - 1)) begin
                    state_nx = ST_STEP;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            ST_STEP: begin
                if (cnt == CNT_W'(DATA_W - 1)) begin
                    state_nx = ST_FINISH;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        capture = 1'b0;
        step_en = 1'b0;
        finish  = 1'b0;
        busy    = 1'b1;
        unique case (state)
            ST_IDLE: begin
                busy    = 1'b0;
                capture = start;
            end
            ST_SETUP:  ;
            ST_STEP:   step_en = 1'b1;
            ST_FINISH: finish  = 1'b1;
            default:   busy    = 1'b0;
        endcase
    end

    initial begin
        if (PAD_CYCLES < 1) $error("TOTAL_CYCLES too small for DATA_W");
    end

    // R4
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R7
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_STEP || state == ST_FINISH) && start) |=> (state != ST_SETUP));
endmodule

// File: rtl/xmul_datapath.sv
module xmul_datapath #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              step_en,
    input  logic              finish,
    input  logic [DATA_W-1:0] mcand_in,
    input  logic [DATA_W-1:0] mplier_in,
    output logic [2*DATA_W-1:0] product
);
    localparam int PROD_W = 2 * DATA_W;

    logic [DATA_W-1:0] mcand_q;
    logic [PROD_W-1:0] prod_q;
    logic [DATA_W:0]   partial;

    // one partial product per step: conditional add into the upper half
    always_comb begin
        partial = {1'b0, prod_q[PROD_W-1:DATA_W]}
                + (prod_q[0] ? {1'b0, mcand_q} : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcand_q <= '0;
            prod_q  <= '0;
        end else if (capture) begin
            mcand_q <= mcand_in;
            prod_q  <= {{DATA_W{1'b0}}, mplier_in};
        end else if (step_en) begin
            prod_q  <= {partial, prod_q[DATA_W-1:1]};
        end
    end

    assign product = prod_q;

    // shadow copies for checking only
    logic [DATA_W-1:0] chk_a, chk_x;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_a <= '0;
            chk_x <= '0;
        end else if (capture) begin
            chk_a <= mplier_in;
            chk_x <= mcand_in;
        end
    end

    // R1
    product_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        finish |-> (prod_q == PROD_W'(chk_a) * PROD_W'(chk_x)));
endmodule

// File: rtl/xmul_unit.sv
module xmul_unit #(
    parameter int DATA_W       = 8,
    parameter int TOTAL_CYCLES = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] idx_in,
    input  logic              cc_half_in,
    input  logic              cc_mask_in,
    input  logic              cc_neg_in,
    input  logic              cc_zero_in,
    input  logic              cc_carry_in,
    output logic [DATA_W-1:0] acc_out,
    output logic [DATA_W-1:0] idx_out,
    output logic              acc_we,
    output logic              idx_we,
    output logic              cc_half_out,
    output logic              cc_mask_out,
    output logic              cc_neg_out,
    output logic              cc_zero_out,
    output logic              cc_carry_out,
    output logic              cc_we,
    output logic              busy,
    output logic              done
);
    localparam int PROD_W = 2 * DATA_W;
    localparam int LAT_W  = $clog2(TOTAL_CYCLES + 1) + 1;

    logic capture, step_en, finish;
    logic [PROD_W-1:0] product;

    xmul_ctrl #(.DATA_W(DATA_W), .TOTAL_CYCLES(TOTAL_CYCLES)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .capture (capture),
        .step_en (step_en),
        .finish  (finish),
        .busy    (busy)
    );

    xmul_datapath #(.DATA_W(DATA_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .step_en   (step_en),
        .finish    (finish),
        .mcand_in  (idx_in),
        .mplier_in (acc_in),
        .product   (product)
    );

    always_comb begin
        done         = finish;
        acc_we       = finish;
        idx_we       = finish;
        cc_we        = finish;
        acc_out      = finish ? product[DATA_W-1:0]      : '0;
        idx_out      = finish ? product[PROD_W-1:DATA_W] : '0;
        cc_half_out  = 1'b0;
        cc_carry_out = 1'b0;
        cc_mask_out  = finish & cc_mask_in;
        cc_neg_out   = finish & cc_neg_in;
        cc_zero_out  = finish & cc_zero_in;
    end

    // independent latency counter for checking
    logic [LAT_W-1:0] lat_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              lat_cnt <= '0;
        else if (start && !busy) lat_cnt <= LAT_W'(1);
        else if (busy)           lat_cnt <= lat_cnt + 1'b1;
    end

    // R2
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_cnt == LAT_W'(TOTAL_CYCLES - 1)));

    // R2
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    write_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we || idx_we) |-> busy);

    // R5
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cc_we |-> (!cc_half_out && !cc_carry_out));
endmodule

// File: tb/xmul_unit_test.sv
module xmul_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] acc_in = '0, idx_in = '0;
    logic       h_in = 1'b0, i_in = 1'b0, n_in = 1'b0, z_in = 1'b0, c_in = 1'b0;
    logic [7:0] acc_out, idx_out;
    logic       acc_we, idx_we, h_out, i_out, n_out, z_out, c_out, cc_we, busy, done;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    typedef struct {
        logic [15:0] prod;
        logic        i, n, z;
        int          due;
    } exp_t;
    exp_t sb[$];

    xmul_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .acc_in(acc_in), .idx_in(idx_in),
        .cc_half_in(h_in), .cc_mask_in(i_in), .cc_neg_in(n_in),
        .cc_zero_in(z_in), .cc_carry_in(c_in),
        .acc_out(acc_out), .idx_out(idx_out), .acc_we(acc_we), .idx_we(idx_we),
        .cc_half_out(h_out), .cc_mask_out(i_out), .cc_neg_out(n_out),
        .cc_zero_out(z_out), .cc_carry_out(c_out), .cc_we(cc_we),
        .busy(busy), .done(done)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // driver: one accepted start, expected item pushed into the scoreboard
    task automatic issue(input logic [7:0] a, input logic [7:0] x,
                         input logic fi, input logic fn, input logic fz);
        exp_t e;
        @(negedge clk);
        acc_in = a; idx_in = x;
        i_in = fi; n_in = fn; z_in = fz;
        h_in = 1'b1; c_in = 1'b1;
        start = 1'b1;
        @(posedge clk); #1;
        e.prod = 16'(a) * 16'(x);
        e.i = fi; e.n = fn; e.z = fz;
        e.due = cyc + 9;
        sb.push_back(e);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // monitor: samples just after each rising edge
    initial begin
        forever begin
            @(posedge clk); #1;
            if (rst_n) begin
                if (done) begin
                    if (sb.size() == 0) begin
                        check(1'b0, "R7 unexpected done", 1, 0);
                    end else begin
                        exp_t e;
                        e = sb.pop_front();
                        check(cyc == e.due, "R2 latency", cyc, e.due);
                        check({idx_out, acc_out} == e.prod, "R1 product", {idx_out, acc_out}, e.prod);
                        check(acc_we && idx_we, "R3 write enables", {acc_we, idx_we}, 3);
                        check(busy, "R4 busy at done", busy, 1);
                        check(cc_we && !h_out && !c_out, "R5 flags", {cc_we, h_out, c_out}, 4);
                        check({i_out, n_out, z_out} == {e.i, e.n, e.z}, "R6 kept flags",
                              {i_out, n_out, z_out}, {e.i, e.n, e.z});
                    end
                end else begin
                    check(!acc_we && !idx_we && acc_out == 0 && idx_out == 0,
                          "R3 idle outputs", {acc_we, idx_we, acc_out, idx_out}, 0);
                    check(!cc_we, "R5 flag write idle", cc_we, 0);
                end
            end
        end
    end

    // watchdog
    initial begin
        #(20 * 20000);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R8 reset state
        repeat (2) @(posedge clk);
        #1;
        check(!busy && !done && !acc_we && !idx_we && !cc_we && acc_out == 0 && idx_out == 0,
              "R8 reset outputs", {busy, done, acc_we, idx_we, cc_we}, 0);
        @(negedge clk);
        start = 1'b1;
        @(posedge clk); #1;
        check(!busy, "R8 start held in reset", busy, 0);
        @(negedge clk);
        start = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy, "R4 idle busy low", busy, 0);

        // R1 basic patterns
        issue(8'd3, 8'd5, 1'b0, 1'b0, 1'b0);
        @(posedge clk); #1;
        check(busy, "R4 busy after start", busy, 1);
        wait_idle();
        check(!busy, "R4 busy low after done", busy, 0);
        issue(8'hFF, 8'hFF, 1'b1, 1'b0, 1'b1);   // R1 corner 0xFE01
        wait_idle();
        issue(8'h00, 8'h9C, 1'b0, 1'b1, 1'b0);   // R1 zero operand
        wait_idle();
        issue(8'hA7, 8'h00, 1'b1, 1'b1, 1'b1);
        wait_idle();
        issue(8'h80, 8'h02, 1'b0, 1'b0, 1'b1);
        wait_idle();
        issue(8'h01, 8'hD3, 1'b1, 1'b0, 1'b0);
        wait_idle();

        // R7 start while busy is ignored
        issue(8'h12, 8'h34, 1'b0, 1'b1, 1'b1);
        repeat (3) @(negedge clk);
        acc_in = 8'h77; idx_in = 8'h66;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        start = 1'b1;                             // lands in late STEP
        @(negedge clk);
        start = 1'b0;
        wait_idle();
        repeat (12) @(negedge clk);
        check(!busy, "R7 no restart", busy, 0);

        // R9 operand changes during the run
        issue(8'hC5, 8'h3B, 1'b1, 1'b0, 1'b1);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            acc_in = 8'(k * 37);
            idx_in = 8'(k * 91 + 5);
        end
        wait_idle();

        // back-to-back: start on the cycle right after done
        issue(8'h0F, 8'hF0, 1'b0, 1'b0, 1'b0);
        while (!done) @(negedge clk);
        issue(8'hAA, 8'h55, 1'b1, 1'b1, 1'b0);
        wait_idle();

        for (int j = 0; j < 6; j++) begin
            issue(8'(j * 53 + 7), 8'(j * 29 + 200), j[0], j[1], j[2]);
            wait_idle();
        end

        check(sb.size() == 0, "R2 all results seen", sb.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule